// File: doc/BRIEF.md
# Triggered Circular Trace Buffer

This block records a debug trace into a 64-word by 16-bit circular store and returns it to a host through one read window. Neighbouring logic supplies qualified strobes: a per-cycle store request with an address, a data value and a cycle-type tag, and a trigger pulse. The block itself does no address comparison and no instruction decoding. A capture kind selects what is written. Change-of-flow mode stores addresses. Event mode stores the data value seen at each trigger. Detail mode stores an address/data pair for each bus cycle. Profile mode turns the read window into a sampler of the latest instruction address.

A separate alignment control chooses between begin alignment and end alignment. With begin alignment, capture waits for the trigger and then runs until the store holds 64 words. With end alignment, capture runs from arming until the trigger and wraps over the oldest words as it goes. The host reads the window (`rd_data`) and pulses `rd_pop` to move on to the next word. `word_cnt` reports how many valid words are held.

Top module: `trace_ring`

## Requirements
- R1: After reset, `armed` is 0, `word_cnt` is 0 and the read window shows 0 (in change-of-flow mode).
- R2: An `arm_req` outside profile mode sets `armed` and clears `word_cnt`, the write position and the read position; no word is stored in that cycle.
- R3: Begin alignment (`end_trig`=0): while armed, nothing is stored before the first `trig`. The trigger cycle's word is stored. Storing continues until `word_cnt` reaches 64, and in that same edge `armed` drops; no later word is stored.
- R4: End alignment (`end_trig`=1): words are stored from the cycle after arming. The word of the cycle in which `trig` arrives is the last one stored, and `armed` drops at that edge.
- R5: `word_cnt` never exceeds 64. Once more than 64 words are written, the oldest entries are overwritten and the read position moves to the oldest valid entry.
- R6: `rd_data` shows the entry at the read position. Each `rd_pop` (outside profile mode) advances that position by one, wrapping from entry 63 to entry 0.
- R7: Change-of-flow mode (`cap_mode`=0) stores `req_addr` of each request tagged 1 (change of flow); other tags are not stored.
- R8: Event mode (`cap_mode`=1) stores `req_data` once per `trig`, whether or not `req` is set. `end_trig` has no effect in this mode, so capture always behaves as begin-aligned.
- R9: Detail mode (`cap_mode`=2) stores each request tagged 0 (data cycle) or 1 (change of flow) as two words, `req_addr` first and `req_data` second, adding 2 to `word_cnt`. Tags 2 (instruction fetch) and 3 (free cycle) store nothing.
- R10: Profile mode (`cap_mode`=3): `rd_data` returns `req_addr` of the latest request tagged 2. `word_cnt` and the store are unchanged, `arm_req` is ignored, and `rd_pop` does not move the read position.
- R11: `disarm_req` drops `armed` at the next edge and wins over a simultaneous `arm_req`. The word of that cycle is still stored if capture is open.
- R12: A store and an `rd_pop` in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_mode | input | 2 | 0 change-of-flow, 1 event, 2 detail, 3 profile |
| end_trig | input | 1 | 1 selects end alignment, 0 begin alignment |
| arm_req | input | 1 | Start a new capture |
| disarm_req | input | 1 | Stop capture |
| trig | input | 1 | Qualified trigger pulse |
| req | input | 1 | Store request valid |
| req_tag | input | 2 | Cycle type: 0 data, 1 change of flow, 2 instruction fetch, 3 free |
| req_addr | input | 16 | Address of the request |
| req_data | input | 16 | Data bus value of the request |
| rd_pop | input | 1 | Host consumed the window word |
| rd_data | output | 16 | Read window |
| word_cnt | output | 7 | Valid words held, 0 to 64 |
| armed | output | 1 | Capture armed |

## Verification
The assertions assume that `cap_mode` and `end_trig` stay fixed while `armed` is high. Under that assumption a begin-aligned capture can never sit armed with a full store, and profile mode never meets an armed capture. The stimulus draws a new mode and alignment only in cycles where the bench's model reports the block disarmed. Arm, disarm, trigger, request and pop strobes are otherwise random and may coincide. This exercises the arm/disarm priority and the case of a store and a pop in the same cycle.

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int DEPTH = 64,
  parameter int W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cap_mode,
  input  logic          end_trig,
  input  logic          arm_req,
  input  logic          disarm_req,
  input  logic          trig,
  input  logic          req,
  input  logic [1:0]    req_tag,
  input  logic [W-1:0]  req_addr,
  input  logic [W-1:0]  req_data,
  input  logic          rd_pop,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] word_cnt,
  output logic          armed
);
  localparam logic [1:0] M_EVT = 2'd1, M_DET = 2'd2, M_PRF = 2'd3;
  localparam logic [1:0] T_COF = 2'd1, T_INSN = 2'd2;
  localparam logic [CW:0]   LIM  = (CW+1)'(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [W-1:0]  last_insn;
  logic          started, prof, end_eff, open_w, ovr, stop;
  logic [1:0]    nwr, wr;
  logic [CW:0]   sum;
  logic [W-1:0]  w0;

  assign prof    = cap_mode == M_PRF;
  assign end_eff = end_trig && cap_mode != M_EVT;
  assign open_w  = armed && !prof && (end_eff || started || trig);

  always_comb begin
    case (cap_mode)
      M_EVT:   nwr = {1'b0, trig};
      M_DET:   nwr = (req && !req_tag[1]) ? 2'd2 : 2'd0;
      M_PRF:   nwr = 2'd0;
      default: nwr = {1'b0, req && req_tag == T_COF};
    endcase
  end

  assign wr      = open_w ? nwr : 2'd0;
  assign w0      = (cap_mode == M_EVT) ? req_data : req_addr;
  assign sum     = {1'b0, word_cnt} + (CW+1)'(wr);
  assign ovr     = sum > LIM;
  assign stop    = armed && (end_eff ? trig : (wr != 2'd0 && sum >= LIM));
  assign rd_data = prof ? last_insn : mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      started   <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
      word_cnt  <= '0;
      last_insn <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (req && req_tag == T_INSN) last_insn <= req_addr;
      if (arm_req && !disarm_req && !prof) begin
        armed    <= 1'b1;
        started  <= 1'b0;
        wptr     <= '0;
        rptr     <= '0;
        word_cnt <= '0;
      end else begin
        if (disarm_req || stop) armed <= 1'b0;
        if (armed && trig) started <= 1'b1;
        if (wr != 2'd0) begin
          mem[wptr] <= w0;
          if (wr[1]) mem[wptr + AW'(1)] <= req_data;
          wptr     <= wptr + AW'(wr);
          word_cnt <= ovr ? FULL : sum[CW-1:0];
        end
        if (wr != 2'd0 && ovr) rptr <= wptr + AW'(wr);
        else if (rd_pop && !prof) rptr <= rptr + AW'(1);
      end
    end
  end

  a_r5_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= FULL);

  a_r3_begin_full_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && !end_eff && !prof && word_cnt == FULL));

  a_r4_end_trig_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && end_eff && trig && !arm_req) |=> !armed);

  a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !disarm_req && !prof) |=> (armed && word_cnt == '0));

  a_r11_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_req |=> !armed);

  a_r10_prof_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    prof |=> $stable(word_cnt));
endmodule

// File: tb/trace_ring_bench.sv
module trace_ring_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  cap_mode = 2'd0, req_tag = 2'd0;
  logic        end_trig = 1'b0, arm_req = 1'b0, disarm_req = 1'b0, trig = 1'b0;
  logic        req = 1'b0, rd_pop = 1'b0;
  logic [15:0] req_addr = 16'h0, req_data = 16'h0;
  logic [15:0] rd_data;
  logic [6:0]  word_cnt;
  logic        armed;

  trace_ring u_trace_ring (.*);

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [15:0] m_mem [64];
  int m_w = 0, m_r = 0, m_cnt = 0;
  bit m_arm = 0, m_st = 0;
  logic [15:0] m_last = 16'h0;

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd();
    return (cap_mode == 2'd3) ? m_last : m_mem[m_r];
  endfunction

  function automatic void model();
    bit prf = cap_mode == 2'd3;
    bit ee  = end_trig && cap_mode != 2'd1;
    bit op, stp, ovr;
    int n = 0;
    if (req && req_tag == 2'd2) m_last = req_addr;
    if (arm_req && !disarm_req && !prf) begin
      m_arm = 1; m_st = 0; m_w = 0; m_r = 0; m_cnt = 0;
      return;
    end
    op = m_arm && !prf && (ee || m_st || trig);
    if (op) begin
      if (cap_mode == 2'd0 && req && req_tag == 2'd1) n = 1;
      if (cap_mode == 2'd1 && trig) n = 1;
      if (cap_mode == 2'd2 && req && req_tag <= 2'd1) n = 2;
    end
    stp = m_arm && (ee ? trig : (n > 0 && m_cnt + n >= 64));
    if (m_arm && trig) m_st = 1;
    ovr = (n > 0) && (m_cnt + n > 64);
    if (n > 0) begin
      m_mem[m_w] = (cap_mode == 2'd1) ? req_data : req_addr;
      if (n == 2) m_mem[(m_w + 1) % 64] = req_data;
      m_w = (m_w + n) % 64;
      m_cnt = ovr ? 64 : m_cnt + n;
    end
    if (ovr) m_r = m_w;
    else if (rd_pop && !prf) m_r = (m_r + 1) % 64;
    if (disarm_req || stp) m_arm = 0;
  endfunction

  task automatic go(bit a, bit d, bit t, bit r, logic [1:0] tg,
                    logic [15:0] ad, logic [15:0] dt, bit p);
    arm_req = a; disarm_req = d; trig = t; req = r; req_tag = tg;
    req_addr = ad; req_data = dt; rd_pop = p;
    model();
    @(posedge clk);
    @(negedge clk);
    chk("R2/R3/R4/R11 armed", armed, m_arm);
    chk("R3/R5 count", word_cnt, m_cnt);
    chk("R6/R10 window", rd_data, exp_rd());
    arm_req = 0; disarm_req = 0; trig = 0; req = 0; rd_pop = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 armed", armed, 0);
    chk("R1 count", word_cnt, 0);
    chk("R1 window", rd_data, 0);

    // R3 R7 begin alignment, change-of-flow
    go(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 armed", armed, 1);
    for (int i = 0; i < 5; i++) go(0, 0, 0, 1, 1, 16'h0F00 + 16'(i), 0, 0);
    chk("R3 no store before trig", word_cnt, 0);
    go(0, 0, 1, 1, 1, 16'h1000, 0, 0);
    chk("R3 trig word stored", word_cnt, 1);
    for (int i = 1; i <= 70; i++) go(0, 0, 0, 1, 1, 16'h1000 + 16'(i), 0, 0);
    chk("R3 full count", word_cnt, 64);
    chk("R3 disarmed", armed, 0);
    chk("R6 first word", rd_data, 16'h1000);
    go(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6 pop advances", rd_data, 16'h1001);
    for (int i = 0; i < 63; i++) go(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6 wrap", rd_data, 16'h1000);

    // R4 R5 end alignment with wrap
    end_trig = 1;
    go(1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) go(0, 0, i == 69, 1, 1, 16'h2000 + 16'(i), 0, 0);
    chk("R4 disarmed", armed, 0);
    chk("R5 saturated", word_cnt, 64);
    chk("R5 oldest first", rd_data, 16'h2006);
    go(0, 0, 0, 1, 1, 16'hDEAD, 0, 0);
    chk("R4 nothing after trig", rd_data, 16'h2006);

    // R9 detail
    cap_mode = 2'd2;
    go(1, 0, 0, 0, 0, 0, 0, 0);
    go(0, 0, 0, 1, 0, 16'h00A0, 16'h00D0, 0);
    go(0, 0, 0, 1, 3, 16'h00B0, 16'h00E0, 0);
    go(0, 0, 0, 1, 2, 16'h00B1, 16'h00E1, 0);
    go(0, 0, 0, 1, 1, 16'h00A1, 16'h00D1, 0);
    chk("R9 count", word_cnt, 4);
    chk("R9 addr first", rd_data, 16'h00A0);
    go(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 data second", rd_data, 16'h00D0);
    go(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 skip fetch/free", rd_data, 16'h00A1);
    go(0, 1, 0, 0, 0, 0, 0, 0);

    // R8 event, end alignment ignored
    cap_mode = 2'd1;
    go(1, 0, 0, 0, 0, 0, 0, 0);
    go(0, 0, 0, 1, 1, 0, 16'h0077, 0);
    chk("R8 no store without trig", word_cnt, 0);
    go(0, 0, 1, 0, 0, 0, 16'h0055, 0);
    chk("R8 event stored", word_cnt, 1);
    chk("R8 still armed", armed, 1);
    chk("R8 event data", rd_data, 16'h0055);
    go(0, 1, 0, 0, 0, 0, 0, 0);

    // R10 profile
    cap_mode = 2'd3;
    go(0, 0, 0, 1, 2, 16'h3333, 0, 0);
    chk("R10 last insn", rd_data, 16'h3333);
    go(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 arm ignored", armed, 0);
    chk("R10 count held", word_cnt, 1);
    go(0, 0, 0, 0, 0, 0, 0, 1);
    cap_mode = 2'd1;
    #1;
    chk("R10 pop no move", rd_data, 16'h0055);

    // R11 R12
    cap_mode = 2'd0;
    go(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R11 disarm wins", armed, 0);
    go(1, 0, 0, 0, 0, 0, 0, 0);
    go(0, 0, 0, 1, 1, 16'h4000, 0, 0);
    go(0, 0, 0, 1, 1, 16'h4001, 0, 1);
    chk("R12 store counted", word_cnt, 2);
    chk("R12 pop taken", rd_data, 16'h4001);
    go(0, 1, 0, 1, 1, 16'h4002, 0, 0);
    chk("R11 last word kept", word_cnt, 3);
    go(0, 0, 0, 1, 1, 16'h4003, 0, 0);
    chk("R11 storing stopped", word_cnt, 3);

    // random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      if (!m_arm && $urandom_range(19) == 0) begin
        cap_mode = 2'($urandom_range(3));
        end_trig = 1'($urandom_range(1));
      end
      go($urandom_range(29) == 0, $urandom_range(149) == 0, $urandom_range(24) == 0,
         1'($urandom_range(1)), 2'($urandom_range(3)), 16'($urandom),
         16'($urandom), $urandom_range(5) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule